// File: doc/BRIEF.md
# K-ary Heap Sift Engine

This block puts a min-priority k-ary heap back in order after one entry has been placed or changed. The heap is kept in two kinds of storage. Node 0, the root, lives in a register outside the block. Every other node lives in a synchronous memory. That memory has one row per parent node, and the row holds all K children of that parent side by side. The row address of a group of children is therefore the index of their parent. A single read returns a whole sibling group.

A start pulse supplies a node index, a direction and the current heap size.

- **Down** (`start_up`=0): the entry at the start node sinks. It swaps with its smallest valid child until no child is smaller or the node has no children.
- **Up** (`start_up`=1): the entry rises. It swaps with its parent while it is strictly smaller, and stops at the root.

Each swap costs three cycles: one compare on freshly fetched data and two write-backs. Only the new row is fetched on each step. The moving entry stays in a register for the whole walk.

The controller is a single state machine:

- `S_IDLE` accepts `start` and goes to `S_DN_WU1` or `S_UP_WU1`.
- Two warm-up states per direction load the first operands:
  - Down: `S_DN_WU1` reads the row that holds the start node. `S_DN_WU2` captures the moving entry and reads the child row, or goes to `S_DONE` if the node has no children.
  - Up: `S_UP_WU1` reads the row that holds the start node. `S_UP_WU2` captures the moving entry and reads the grandparent row, or goes to `S_DONE` at the root.
- The steady loop is compare, write-back 1, write-back 2:
  - Down: `S_DN_CMP` goes to `S_DN_WB1` on a swap, otherwise to `S_DONE`. `S_DN_WB1` goes to `S_DN_WB2`. `S_DN_WB2` goes back to `S_DN_CMP` while the new node has children, otherwise to `S_DONE`.
  - Up: `S_UP_CMP`, `S_UP_WB1` and `S_UP_WB2` follow the same pattern. `S_UP_WB2` leaves for `S_DONE` once the moving entry sits in the root.
- `S_DONE` raises `done` for one cycle and returns to `S_IDLE`.

Top module: `heap_sift`

## Requirements
- R1: An entry is packed MSB to LSB as {cyclic priority (CPW bits), normal priority (NPW bits), reference id (IDW bits)}. Order is the unsigned compare of the upper CPW+NPW bits, so cyclic priority dominates and normal priority breaks ties. The id never affects order, and equal keys never cause a swap.
- R2: Going down, the moving entry swaps with the valid child holding the smallest key. When several children tie for smallest, the lowest slot wins. The walk stops when no valid child is strictly smaller or the node has no valid child.
- R3: Going up, the moving entry swaps with its parent while its key is strictly smaller, and stops after it reaches node 0.
- R4: Node 0 is the external root register. Node i>0 is in memory row (i-1)/K, slot (i-1)%K, with slot s at bits [s*EW +: EW] of a row. The children of node p fill row p.
- R5: Only children with index below `heap_size` are compared. Slots at or beyond the size are never selected and never written.
- R6: Every memory write carries a one-hot mask selecting exactly one slot. The other slots of the row keep their contents.
- R7: `done` is a one-cycle pulse. It is high on the 3+3s+c-th rising edge after the edge that samples `start`, where s is the number of swaps and c is 1 if the walk ended on a compare that found order already holding, else 0.
- R8: Each swap makes exactly two write-backs. A fetch in the same cycle as a write-back always addresses a different row. A swap is never written to memory and the root in one cycle.
- R9: During and after reset the block is idle: no `done`, no read, no write.
- R10: A down start at a node without valid children, or an up start at node 0, makes no write and signals `done` after 3 edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (sampled in idle) |
| start_up | input | 1 | 1 = walk up, 0 = walk down |
| start_idx | input | IDXW | Starting node index |
| heap_size | input | IDXW+1 | Number of valid nodes |
| done | output | 1 | One-cycle completion pulse |
| root_q | input | EW | Current root register value |
| root_we | output | 1 | Root register write enable |
| root_wd | output | EW | Root register write data |
| mem_rd_en | output | 1 | Row read enable (data next cycle) |
| mem_rd_addr | output | ROWW | Row read address |
| mem_rd_data | input | K*EW | Row read data |
| mem_wr_en | output | 1 | Row write enable |
| mem_wr_addr | output | ROWW | Row write address |
| mem_wr_data | output | K*EW | Row write data |
| mem_wr_mask | output | K | Per-slot write mask |

## Verification
The fetch of the next row and the second write-back of a swap happen in the same cycle. Going down, the fetch reads the child row of the node just reached while its own slot is written. Going up, it reads the grandparent row while the parent slot is written. Walks of two or three swaps in each direction provoke this overlap. The bench judges each walk by comparing the whole root-plus-memory image against a reference sift and by counting writes and cycles. A checker confirms that the read and write rows never coincide.

// File: rtl/heap_sift_pkg.sv
package heap_sift_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DN_WU1,
        S_DN_WU2,
        S_DN_CMP,
        S_DN_WB1,
        S_DN_WB2,
        S_UP_WU1,
        S_UP_WU2,
        S_UP_CMP,
        S_UP_WB1,
        S_UP_WB2,
        S_DONE
    } sift_state_e;

endpackage

// File: rtl/heap_idx_calc.sv
module heap_idx_calc #(
    parameter int IDXW = 8,
    parameter int LOGK = 2
) (
    input  logic [IDXW-1:0]      node,
    output logic [IDXW-LOGK-1:0] row,
    output logic [LOGK-1:0]      slot,
    output logic                 is_root
);

    logic [IDXW-1:0] offs;

    // node i>0 sits in row (i-1)/K at slot (i-1)%K
    assign offs    = node - IDXW'(1);
    assign row     = offs[IDXW-1:LOGK];
    assign slot    = offs[LOGK-1:0];
    assign is_root = (node == '0);

endmodule

// File: rtl/heap_min_select.sv
module heap_min_select #(
    parameter int K    = 4,
    parameter int EW   = 18,
    parameter int KEYW = 12,
    localparam int LOGK = $clog2(K)
) (
    input  logic [K*EW-1:0] row_data,
    input  logic [K-1:0]    valid,
    output logic [LOGK-1:0] best_slot,
    output logic [EW-1:0]   best_entry
);

    logic          found;
    logic [EW-1:0] cand;

    // linear scan, strict less keeps the lowest slot on ties
    always_comb begin
        best_slot  = '0;
        best_entry = row_data[EW-1:0];
        found      = 1'b0;
        cand       = '0;
        for (int j = 0; j < K; j++) begin
            cand = row_data[j*EW +: EW];
            if (valid[j] && (!found || (cand[EW-1 -: KEYW] < best_entry[EW-1 -: KEYW]))) begin
                best_slot  = LOGK'(j);
                best_entry = cand;
                found      = 1'b1;
            end
        end
    end

endmodule

// File: rtl/heap_sift.sv
module heap_sift #(
    parameter int K    = 4,
    parameter int IDXW = 8,
    parameter int CPW  = 4,
    parameter int NPW  = 8,
    parameter int IDW  = 6,
    localparam int EW   = CPW + NPW + IDW,
    localparam int LOGK = $clog2(K),
    localparam int ROWW = IDXW - LOGK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              start_up,
    input  logic [IDXW-1:0]   start_idx,
    input  logic [IDXW:0]     heap_size,
    output logic              done,
    input  logic [EW-1:0]     root_q,
    output logic              root_we,
    output logic [EW-1:0]     root_wd,
    output logic              mem_rd_en,
    output logic [ROWW-1:0]   mem_rd_addr,
    input  logic [K*EW-1:0]   mem_rd_data,
    output logic              mem_wr_en,
    output logic [ROWW-1:0]   mem_wr_addr,
    output logic [K*EW-1:0]   mem_wr_data,
    output logic [K-1:0]      mem_wr_mask
);

    import heap_sift_pkg::*;

    localparam int KEYW = CPW + NPW;
    localparam int CW   = IDXW + LOGK + 1;

    sift_state_e state_q, state_d;

    logic [IDXW-1:0] cur_q;
    logic [EW-1:0]   hold_q;
    logic [EW-1:0]   swap_q;
    logic [LOGK-1:0] slot_q;
    logic [IDXW:0]   size_q;

    logic [ROWW-1:0] row_cur, row_par;
    logic [LOGK-1:0] slot_cur, slot_par;
    logic            root_cur, root_par;

    logic [CW-1:0]   first_child;
    logic [K-1:0]    kid_ok;
    logic [LOGK-1:0] min_slot;
    logic [EW-1:0]   min_entry;
    logic [EW-1:0]   cur_rd, par_rd, up_par;
    logic [EW-1:0]   wb_data;
    logic            wb_active;

    function automatic logic key_less(input logic [EW-1:0] a, input logic [EW-1:0] b);
        return a[EW-1 -: KEYW] < b[EW-1 -: KEYW];
    endfunction

    heap_idx_calc #(.IDXW(IDXW), .LOGK(LOGK)) u_idx_cur (
        .node    (cur_q),
        .row     (row_cur),
        .slot    (slot_cur),
        .is_root (root_cur)
    );

    heap_idx_calc #(.IDXW(IDXW), .LOGK(LOGK)) u_idx_par (
        .node    (IDXW'(row_cur)),
        .row     (row_par),
        .slot    (slot_par),
        .is_root (root_par)
    );

    assign first_child = {1'b0, cur_q, {LOGK{1'b0}}} + CW'(1);

    generate
        for (genvar j = 0; j < K; j++) begin : g_kid
            assign kid_ok[j] = (first_child + CW'(j)) < CW'(size_q);
        end
    endgenerate

    heap_min_select #(.K(K), .EW(EW), .KEYW(KEYW)) u_min (
        .row_data   (mem_rd_data),
        .valid      (kid_ok),
        .best_slot  (min_slot),
        .best_entry (min_entry)
    );

    assign cur_rd = mem_rd_data[slot_cur*EW +: EW];
    assign par_rd = mem_rd_data[slot_par*EW +: EW];
    assign up_par = root_par ? root_q : par_rd;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (start) state_d = start_up ? S_UP_WU1 : S_DN_WU1;
            S_DN_WU1: state_d = S_DN_WU2;
            S_DN_WU2: state_d = kid_ok[0] ? S_DN_CMP : S_DONE;
            S_DN_CMP: state_d = key_less(min_entry, hold_q) ? S_DN_WB1 : S_DONE;
            S_DN_WB1: state_d = S_DN_WB2;
            S_DN_WB2: state_d = kid_ok[0] ? S_DN_CMP : S_DONE;
            S_UP_WU1: state_d = S_UP_WU2;
            S_UP_WU2: state_d = root_cur ? S_DONE : S_UP_CMP;
            S_UP_CMP: state_d = key_less(hold_q, up_par) ? S_UP_WB1 : S_DONE;
            S_UP_WB1: state_d = S_UP_WB2;
            S_UP_WB2: state_d = root_cur ? S_DONE : S_UP_CMP;
            S_DONE:   state_d = S_IDLE;
            default:  state_d = S_IDLE;
        endcase
    end

    // walk registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q  <= '0;
            hold_q <= '0;
            swap_q <= '0;
            slot_q <= '0;
            size_q <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start) begin
                    cur_q  <= start_idx;
                    size_q <= heap_size;
                end
                S_DN_WU2: hold_q <= root_cur ? root_q : cur_rd;
                S_DN_CMP: begin
                    swap_q <= min_entry;
                    slot_q <= min_slot;
                end
                S_DN_WB1: cur_q  <= first_child[IDXW-1:0] + IDXW'(slot_q);
                S_UP_WU2: hold_q <= cur_rd;
                S_UP_CMP: swap_q <= up_par;
                S_UP_WB1: cur_q  <= IDXW'(row_cur);
                default: ;
            endcase
        end
    end

    // memory and root ports
    always_comb begin
        mem_rd_en   = 1'b0;
        mem_rd_addr = '0;
        mem_wr_en   = 1'b0;
        mem_wr_addr = '0;
        mem_wr_data = '0;
        mem_wr_mask = '0;
        root_we     = 1'b0;
        root_wd     = '0;
        wb_active   = 1'b0;
        wb_data     = hold_q;
        unique case (state_q)
            S_DN_WU1, S_UP_WU1: if (!root_cur) begin
                mem_rd_en   = 1'b1;
                mem_rd_addr = row_cur;
            end
            S_DN_WU2: if (kid_ok[0]) begin
                mem_rd_en   = 1'b1;
                mem_rd_addr = cur_q[ROWW-1:0];
            end
            S_DN_WB2: begin
                wb_active = 1'b1;
                if (kid_ok[0]) begin
                    mem_rd_en   = 1'b1;
                    mem_rd_addr = cur_q[ROWW-1:0];
                end
            end
            S_UP_WU2: if (!root_cur && !root_par) begin
                mem_rd_en   = 1'b1;
                mem_rd_addr = row_par;
            end
            S_UP_WB2: begin
                wb_active = 1'b1;
                if (!root_cur && !root_par) begin
                    mem_rd_en   = 1'b1;
                    mem_rd_addr = row_par;
                end
            end
            S_DN_WB1, S_UP_WB1: begin
                wb_active = 1'b1;
                wb_data   = swap_q;
            end
            default: ;
        endcase
        if (wb_active) begin
            if (root_cur) begin
                root_we = 1'b1;
                root_wd = wb_data;
            end else begin
                mem_wr_en   = 1'b1;
                mem_wr_addr = row_cur;
                mem_wr_mask = K'(1) << slot_cur;
                mem_wr_data = {K{wb_data}};
            end
        end
    end

    assign done = (state_q == S_DONE);

endmodule

// File: rtl/heap_sift_chk.sv
module heap_sift_chk #(
    parameter int K    = 4,
    parameter int ROWW = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            done,
    input logic            root_we,
    input logic            mem_rd_en,
    input logic [ROWW-1:0] mem_rd_addr,
    input logic            mem_wr_en,
    input logic [ROWW-1:0] mem_wr_addr,
    input logic [K-1:0]    mem_wr_mask
);

    logic wr_any;
    assign wr_any = mem_wr_en | root_we;

    a_r6_onehot_mask: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> ($countones(mem_wr_mask) == 1));

    a_r8_rows_apart: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_en && mem_wr_en) |-> (mem_rd_addr != mem_wr_addr));

    a_r8_one_target: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr_en && root_we));

    a_r8_paired_writes: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_any) |=> wr_any);

    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_quiet_on_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mem_rd_en && !mem_wr_en && !root_we));

endmodule

bind heap_sift heap_sift_chk #(.K(K), .ROWW(ROWW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .done        (done),
    .root_we     (root_we),
    .mem_rd_en   (mem_rd_en),
    .mem_rd_addr (mem_rd_addr),
    .mem_wr_en   (mem_wr_en),
    .mem_wr_addr (mem_wr_addr),
    .mem_wr_mask (mem_wr_mask)
);

// File: tb/heap_sift_test.sv
`timescale 1ns/1ps
module heap_sift_test;

    localparam int K    = 4;
    localparam int IDXW = 8;
    localparam int CPW  = 4;
    localparam int NPW  = 8;
    localparam int IDW  = 6;
    localparam int EW   = CPW + NPW + IDW;
    localparam int ROWW = IDXW - 2;
    localparam int ROWS = 1 << ROWW;
    localparam int NN   = 64;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic              start_up = 1'b0;
    logic [IDXW-1:0]   start_idx = '0;
    logic [IDXW:0]     heap_size = '0;
    logic              done;
    logic [EW-1:0]     root_r;
    logic              root_we;
    logic [EW-1:0]     root_wd;
    logic              mem_rd_en;
    logic [ROWW-1:0]   mem_rd_addr;
    logic [K*EW-1:0]   rdq;
    logic              mem_wr_en;
    logic [ROWW-1:0]   mem_wr_addr;
    logic [K*EW-1:0]   mem_wr_data;
    logic [K-1:0]      mem_wr_mask;

    logic [K*EW-1:0]   mem [ROWS];
    logic [EW-1:0]     exp_n [NN];
    int                wr_cnt = 0;
    int                mask_bad = 0;
    int                n_checks = 0;
    int                n_fail = 0;

    always #2.5 clk = ~clk;

    heap_sift #(.K(K), .IDXW(IDXW), .CPW(CPW), .NPW(NPW), .IDW(IDW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_up(start_up),
        .start_idx(start_idx), .heap_size(heap_size), .done(done),
        .root_q(root_r), .root_we(root_we), .root_wd(root_wd),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(rdq),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr),
        .mem_wr_data(mem_wr_data), .mem_wr_mask(mem_wr_mask)
    );

    // memory and root register models
    always @(posedge clk) begin
        if (mem_rd_en) rdq <= mem[mem_rd_addr];
        if (mem_wr_en) begin
            wr_cnt <= wr_cnt + 1;
            if ($countones(mem_wr_mask) != 1) mask_bad <= mask_bad + 1;
            for (int j = 0; j < K; j++)
                if (mem_wr_mask[j]) mem[mem_wr_addr][j*EW +: EW] <= mem_wr_data[j*EW +: EW];
        end
        if (root_we) begin
            wr_cnt <= wr_cnt + 1;
            root_r <= root_wd;
        end
    end

    function automatic logic [EW-1:0] mk(input int c, input int n, input int id);
        return {c[CPW-1:0], n[NPW-1:0], id[IDW-1:0]};
    endfunction

    function automatic logic [CPW+NPW-1:0] key(input logic [EW-1:0] e);
        return e[EW-1:IDW];
    endfunction

    function automatic logic [EW-1:0] node_val(input int i);
        if (i == 0) return root_r;
        return mem[(i-1)/K][((i-1)%K)*EW +: EW];
    endfunction

    task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    // every node gets a junk entry with key 0 (smaller than anything real)
    task automatic fill_junk();
        for (int i = 0; i < NN; i++) exp_n[i] = mk(0, 0, i);
    endtask

    task automatic push_image();
        @(negedge clk);
        root_r <= exp_n[0];
        for (int i = 1; i < NN; i++) mem[(i-1)/K][((i-1)%K)*EW +: EW] <= exp_n[i];
    endtask

    task automatic ref_sift(input bit up, input int idx, input int size, output int s, output bit ce);
        int p, c, fc, m;
        logic [EW-1:0] t;
        s = 0; ce = 1'b0;
        if (!up) begin
            p = idx;
            forever begin
                fc = p*K + 1;
                if (fc >= size) break;
                m = -1;
                for (int j = 0; j < K; j++)
                    if (fc + j < size && (m < 0 || key(exp_n[fc+j]) < key(exp_n[m]))) m = fc + j;
                if (key(exp_n[m]) < key(exp_n[p])) begin
                    t = exp_n[m]; exp_n[m] = exp_n[p]; exp_n[p] = t; s++; p = m;
                end else begin
                    ce = 1'b1; break;
                end
            end
        end else begin
            c = idx;
            while (c > 0) begin
                p = (c-1)/K;
                if (key(exp_n[c]) < key(exp_n[p])) begin
                    t = exp_n[c]; exp_n[c] = exp_n[p]; exp_n[p] = t; s++; c = p;
                end else begin
                    ce = 1'b1; break;
                end
            end
        end
    endtask

    task automatic run_case(input bit up, input int idx, input int size, input string tags);
        int s, cyc, w0, mb0, mism;
        bit ce;
        push_image();
        ref_sift(up, idx, size, s, ce);
        w0 = wr_cnt; mb0 = mask_bad;
        @(negedge clk);
        start = 1'b1; start_up = up; start_idx = idx[IDXW-1:0]; heap_size = size[IDXW:0];
        @(negedge clk);
        start = 1'b0;
        cyc = 1;
        while (!done && cyc < 1000) begin
            @(negedge clk);
            cyc++;
        end
        chk(cyc == 3 + 3*s + int'(ce), {tags, " R7"}, "cycles to done", cyc, 3 + 3*s + int'(ce));
        chk(wr_cnt - w0 == 2*s, {tags, " R8"}, "write count", wr_cnt - w0, 2*s);
        chk(mask_bad == mb0, {tags, " R6"}, "non-one-hot masks", mask_bad - mb0, 0);
        mism = 0;
        for (int i = 0; i < NN; i++) if (node_val(i) !== exp_n[i]) mism++;
        chk(mism == 0, tags, "heap image mismatches", mism, 0);
        @(negedge clk);
        chk(!done, "R7", "done still high", int'(done), 0);
    endtask

    task automatic t_reset();
        chk(!done && !mem_rd_en && !mem_wr_en && !root_we, "R9", "activity in reset",
            int'({done, mem_rd_en, mem_wr_en, root_we}), 0);
        @(negedge clk); rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(!done && !mem_rd_en && !mem_wr_en && !root_we, "R9", "activity after reset",
            int'({done, mem_rd_en, mem_wr_en, root_we}), 0);
    endtask

    task automatic t_down_multi();     // R2 R4 R5: two levels, ends at leaf
        fill_junk();
        for (int i = 1; i < 21; i++) exp_n[i] = mk(0, 3*i, i);
        exp_n[0] = mk(0, 200, 0);
        run_case(1'b0, 0, 21, "R2 R4 R5");
        fill_junk();
        for (int i = 1; i < 21; i++) exp_n[i] = mk(0, 3*i, i);
        exp_n[0] = mk(0, 10, 0);    // one swap, then stops on compare
        run_case(1'b0, 0, 21, "R2");
    endtask

    task automatic t_tie();            // R2 lowest slot wins
        fill_junk();
        exp_n[0] = mk(0, 100, 0); exp_n[1] = mk(0, 50, 1);
        exp_n[2] = mk(0, 20, 2);  exp_n[3] = mk(0, 20, 3); exp_n[4] = mk(0, 60, 4);
        run_case(1'b0, 0, 5, "R2 tie");
    endtask

    task automatic t_lex();            // R1 cyclic field dominates
        fill_junk();
        exp_n[0] = mk(1, 5, 0); exp_n[1] = mk(1, 0, 1);
        exp_n[2] = mk(2, 0, 2); exp_n[3] = mk(0, 250, 3); exp_n[4] = mk(2, 0, 4);
        run_case(1'b0, 0, 5, "R1 lexicographic");
    endtask

    task automatic t_equal();          // R1 equal key, different id: no swap
        fill_junk();
        exp_n[0] = mk(0, 40, 9); exp_n[1] = mk(0, 40, 1);
        for (int i = 2; i < 5; i++) exp_n[i] = mk(0, 70, i);
        run_case(1'b0, 0, 5, "R1 equal");
    endtask

    task automatic t_up();             // R3 to the root and stopping midway
        fill_junk();
        for (int i = 0; i < 30; i++) exp_n[i] = mk(0, 10 + 3*i, i);
        exp_n[29] = mk(0, 1, 29);
        run_case(1'b1, 29, 30, "R3 R4 to root");
        fill_junk();
        for (int i = 0; i < 30; i++) exp_n[i] = mk(0, 10 + 3*i, i);
        exp_n[29] = mk(0, 20, 29);
        run_case(1'b1, 29, 30, "R3 midway");
    endtask

    task automatic t_ends();           // R10 immediate completion
        fill_junk();
        for (int i = 0; i < 11; i++) exp_n[i] = mk(0, 100 - i, i);
        run_case(1'b0, 10, 11, "R10 leaf");
        run_case(1'b1, 0, 11, "R10 root");
    endtask

    task automatic t_mid_down();       // R4 start inside the tree
        fill_junk();
        for (int i = 0; i < 40; i++) exp_n[i] = mk(0, 5 + 2*i, i);
        exp_n[2] = mk(0, 250, 2);
        run_case(1'b0, 2, 40, "R4 R8 mid");
    endtask

    task automatic t_partial();        // R5 smaller junk beyond size ignored
        fill_junk();
        exp_n[0] = mk(0, 100, 0); exp_n[1] = mk(0, 50, 1); exp_n[2] = mk(0, 40, 2);
        run_case(1'b0, 0, 3, "R5 partial row");
    endtask

    initial begin
        for (int r = 0; r < ROWS; r++) mem[r] = '0;
        root_r = '0;
        rdq = '0;
    end

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        t_down_multi();
        t_tie();
        t_lex();
        t_equal();
        t_up();
        t_ends();
        t_mid_down();
        t_partial();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule